// File: doc/BRIEF.md
# Segment access-rights check unit

This block decides whether the access rights of a segment descriptor may be handed to software. If they may, it returns a masked copy of the descriptor's access-rights word. A request carries five things: the selector's offset into the descriptor table with the table's limit, the descriptor's type and privilege level, the current and requested privilege levels, the raw access-rights word, and an operand-size code. The unit checks the limit, the type and the privilege levels. It answers one clock later with a result-valid pulse, a zero flag, a destination write enable and the shaped destination value.

A failed check does not raise a fault. It is reported by clearing the zero flag and withholding the destination write. Conforming code segments skip the privilege comparison. The set of descriptor types that may be queried is not fixed in logic. A 16-bit mask indexed by the descriptor type supplies it, with a separate input flagging conforming code.

Top module: `acr_unit`

## Requirements
- R1: While reset is asserted and after its release, res_vld, dest_we, zf and dest_val are all zero until the first request.
- R2: res_vld is high exactly in the cycle after a cycle with req_vld high, and low otherwise.
- R3: A request whose sel_off is greater than tbl_limit fails; sel_off equal to tbl_limit passes the limit check.
- R4: A request fails when bit desc_type of type_ok_mask is 0 (bit index equals the 4-bit type value).
- R5: For a descriptor with is_conf_code low, the request fails when cur_pl > desc_dpl or req_pl > desc_dpl (unsigned compare).
- R6: For a descriptor with is_conf_code high, the privilege levels do not affect the outcome.
- R7: A request that passes all checks gives zf = 1 and dest_we = 1 in the result cycle.
- R8: With op_size 2'b00 (16-bit), dest_val equals ar_word AND 0xFF00, and bits 63:16 are zero.
- R9: With op_size 2'b01 (32-bit), 2'b10 or 2'b11 (both 64-bit), dest_val equals ar_word AND 0x00F0FF00, zero-extended to 64 bits. Bits 19:16 are always zero.
- R10: A failed request gives zf = 0, dest_we = 0 and dest_val = 0 in the result cycle.
- R11: In a cycle after one with no request, dest_we is 0 and zf and dest_val keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| sel_off | input | 16 | Selector offset into the descriptor table |
| tbl_limit | input | 16 | Descriptor table limit |
| desc_type | input | 4 | Descriptor type code |
| type_ok_mask | input | 16 | Per-type permission mask, indexed by desc_type |
| is_conf_code | input | 1 | Descriptor is a conforming code segment |
| desc_dpl | input | 2 | Descriptor privilege level |
| cur_pl | input | 2 | Current privilege level |
| req_pl | input | 2 | Requested privilege level of the selector |
| ar_word | input | 32 | Raw access-rights word of the descriptor |
| op_size | input | 2 | Operand size: 00 16-bit, 01 32-bit, 10/11 64-bit |
| res_vld | output | 1 | Result valid pulse |
| dest_val | output | 64 | Masked access-rights value |
| dest_we | output | 1 | Destination write enable |
| zf | output | 1 | Zero flag: 1 on success |

## Verification
The assertions assume that every request input holds a known value in any cycle where req_vld is high. They also assume that the inputs change only between clock edges. When no request is present, the inputs may hold arbitrary values. The stimulus applies all inputs on the falling edge. On idle cycles it fills them with random values, so that the hold behaviour is exercised against inputs that keep changing. Offsets are drawn from a small range next to the limit, so that both outcomes of the limit check, and the equal case, occur often.

// File: rtl/acr_pkg.sv
package acr_pkg;
  typedef enum logic [1:0] {
    OPS_16  = 2'b00,
    OPS_32  = 2'b01,
    OPS_64  = 2'b10,
    OPS_64X = 2'b11
  } opsize_e;

  // bit ranges that survive the shaping
  localparam int unsigned LOW_KEEP_LO  = 8;
  localparam int unsigned LOW_KEEP_HI  = 15;
  localparam int unsigned WIDE_KEEP_LO = 20;
  localparam int unsigned WIDE_KEEP_HI = 23;
endpackage

// File: rtl/acr_gate.sv
module acr_gate #(
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned PL_W   = 2,
  parameter int unsigned TYPE_W = 4,
  localparam int unsigned NTYPE = 1 << TYPE_W
) (
  input  logic [OFF_W-1:0]  sel_off,
  input  logic [OFF_W-1:0]  tbl_limit,
  input  logic [TYPE_W-1:0] desc_type,
  input  logic [NTYPE-1:0]  type_ok_mask,
  input  logic              is_conf_code,
  input  logic [PL_W-1:0]   desc_dpl,
  input  logic [PL_W-1:0]   cur_pl,
  input  logic [PL_W-1:0]   req_pl,
  output logic              pass
);
  logic lim_ok;
  logic type_ok;
  logic priv_ok;

  always_comb begin
    lim_ok  = (sel_off <= tbl_limit);
    type_ok = type_ok_mask[desc_type];
    priv_ok = is_conf_code || ((cur_pl <= desc_dpl) && (req_pl <= desc_dpl));
    pass    = lim_ok && type_ok && priv_ok;
  end
endmodule

// File: rtl/acr_shaper.sv
module acr_shaper
  import acr_pkg::*;
#(
  parameter int unsigned AR_W   = 32,
  parameter int unsigned DEST_W = 64
) (
  input  logic [AR_W-1:0]   ar_word,
  input  logic [1:0]        op_size,
  output logic [DEST_W-1:0] shaped
);
  logic narrow;
  assign narrow = (op_size == OPS_16);

  for (genvar i = 0; i < DEST_W; i++) begin : g_bit
    if (i < AR_W) begin : g_src
      localparam bit KEEP_LOW  = (i >= LOW_KEEP_LO) && (i <= LOW_KEEP_HI);
      localparam bit KEEP_WIDE = (i >= WIDE_KEEP_LO) && (i <= WIDE_KEEP_HI);
      if (KEEP_LOW) begin : g_low
        assign shaped[i] = ar_word[i];
      end else if (KEEP_WIDE) begin : g_wide
        assign shaped[i] = ar_word[i] & ~narrow;
      end else begin : g_clr
        assign shaped[i] = 1'b0;
      end
    end else begin : g_ext
      assign shaped[i] = 1'b0;
    end
  end
endmodule

// File: rtl/acr_result_reg.sv
module acr_result_reg #(
  parameter int unsigned DEST_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              pass,
  input  logic [DEST_W-1:0] shaped,
  output logic              res_vld,
  output logic [DEST_W-1:0] dest_val,
  output logic              dest_we,
  output logic              zf
);
  logic              vld_q, vld_d;
  logic              we_q, we_d;
  logic              zf_q, zf_d;
  logic [DEST_W-1:0] val_q, val_d;
  logic              upd_en;

  assign upd_en = req_vld;

  always_comb begin
    vld_d = req_vld;
    we_d  = req_vld && pass;
    zf_d  = pass;
    val_d = pass ? shaped : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      we_q  <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zf_q  <= 1'b0;
      val_q <= '0;
    end else if (upd_en) begin
      zf_q  <= zf_d;
      val_q <= val_d;
    end
  end

  assign res_vld  = vld_q;
  assign dest_we  = we_q;
  assign zf       = zf_q;
  assign dest_val = val_q;
endmodule

// File: rtl/acr_unit.sv
module acr_unit #(
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned PL_W   = 2,
  parameter int unsigned TYPE_W = 4,
  parameter int unsigned AR_W   = 32,
  parameter int unsigned DEST_W = 64,
  localparam int unsigned NTYPE = 1 << TYPE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [OFF_W-1:0]  sel_off,
  input  logic [OFF_W-1:0]  tbl_limit,
  input  logic [TYPE_W-1:0] desc_type,
  input  logic [NTYPE-1:0]  type_ok_mask,
  input  logic              is_conf_code,
  input  logic [PL_W-1:0]   desc_dpl,
  input  logic [PL_W-1:0]   cur_pl,
  input  logic [PL_W-1:0]   req_pl,
  input  logic [AR_W-1:0]   ar_word,
  input  logic [1:0]        op_size,
  output logic              res_vld,
  output logic [DEST_W-1:0] dest_val,
  output logic              dest_we,
  output logic              zf
);
  logic              pass;
  logic [DEST_W-1:0] shaped;

  acr_gate #(.OFF_W(OFF_W), .PL_W(PL_W), .TYPE_W(TYPE_W)) u_gate (
    .sel_off      (sel_off),
    .tbl_limit    (tbl_limit),
    .desc_type    (desc_type),
    .type_ok_mask (type_ok_mask),
    .is_conf_code (is_conf_code),
    .desc_dpl     (desc_dpl),
    .cur_pl       (cur_pl),
    .req_pl       (req_pl),
    .pass         (pass)
  );

  acr_shaper #(.AR_W(AR_W), .DEST_W(DEST_W)) u_shape (
    .ar_word (ar_word),
    .op_size (op_size),
    .shaped  (shaped)
  );

  acr_result_reg #(.DEST_W(DEST_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .pass     (pass),
    .shaped   (shaped),
    .res_vld  (res_vld),
    .dest_val (dest_val),
    .dest_we  (dest_we),
    .zf       (zf)
  );
endmodule

// File: rtl/acr_checker.sv
module acr_checker #(
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned PL_W   = 2,
  parameter int unsigned DEST_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic [OFF_W-1:0]  sel_off,
  input logic [OFF_W-1:0]  tbl_limit,
  input logic              is_conf_code,
  input logic [PL_W-1:0]   desc_dpl,
  input logic [PL_W-1:0]   cur_pl,
  input logic [PL_W-1:0]   req_pl,
  input logic [1:0]        op_size,
  input logic              res_vld,
  input logic [DEST_W-1:0] dest_val,
  input logic              dest_we,
  input logic              zf
);
  AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_vld); // R2
  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !res_vld); // R2
  AST_OVER_LIMIT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (sel_off > tbl_limit)) |=> !zf && !dest_we); // R3
  AST_PRIV_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !is_conf_code && ((cur_pl > desc_dpl) || (req_pl > desc_dpl)))
    |=> !zf && !dest_we); // R5
  AST_WE_MATCHES_ZF: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (dest_we == zf)); // R7
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (op_size == 2'b00)) |=> (dest_val[DEST_W-1:16] == '0)); // R8
  AST_GAP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (dest_val[19:16] == 4'h0) && (dest_val[DEST_W-1:24] == '0)); // R9
  AST_FAIL_CLEARS_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !zf) |-> (dest_val == '0)); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> $stable(zf) && $stable(dest_val) && !dest_we); // R11
endmodule

bind acr_unit acr_checker #(.OFF_W(OFF_W), .PL_W(PL_W), .DEST_W(DEST_W)) u_acr_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_vld      (req_vld),
  .sel_off      (sel_off),
  .tbl_limit    (tbl_limit),
  .is_conf_code (is_conf_code),
  .desc_dpl     (desc_dpl),
  .cur_pl       (cur_pl),
  .req_pl       (req_pl),
  .op_size      (op_size),
  .res_vld      (res_vld),
  .dest_val     (dest_val),
  .dest_we      (dest_we),
  .zf           (zf)
);

// File: tb/acr_unit_bench.sv
`timescale 1ns/1ps
module acr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld;
  logic [15:0] sel_off, tbl_limit;
  logic [3:0]  desc_type;
  logic [15:0] type_ok_mask;
  logic        is_conf_code;
  logic [1:0]  desc_dpl, cur_pl, req_pl;
  logic [31:0] ar_word;
  logic [1:0]  op_size;
  logic        res_vld, dest_we, zf;
  logic [63:0] dest_val;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit model_on = 0;

  // behavioural reference state
  bit          m_vld, m_we, m_zf;
  logic [63:0] m_val;
  string       m_tag;
  string       m_ftag;

  always #2 clk = ~clk;

  acr_unit u_acr_unit (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .sel_off(sel_off),
    .tbl_limit(tbl_limit), .desc_type(desc_type), .type_ok_mask(type_ok_mask),
    .is_conf_code(is_conf_code), .desc_dpl(desc_dpl), .cur_pl(cur_pl),
    .req_pl(req_pl), .ar_word(ar_word), .op_size(op_size),
    .res_vld(res_vld), .dest_val(dest_val), .dest_we(dest_we), .zf(zf)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vld <= 0; m_we <= 0; m_zf <= 0; m_val <= 64'd0; m_tag <= "R1"; m_ftag <= "R1";
    end else if (!req_vld) begin
      m_vld <= 0; m_we <= 0; m_tag <= "R11"; m_ftag <= "R11";
    end else begin
      bit ok;
      string t;
      ok = 1; t = "";
      if (int'(sel_off) > int'(tbl_limit)) begin ok = 0; t = "R3"; end
      else if (type_ok_mask[desc_type] == 1'b0) begin ok = 0; t = "R4"; end
      else if (!is_conf_code && (int'(cur_pl) > int'(desc_dpl) || int'(req_pl) > int'(desc_dpl)))
        begin ok = 0; t = "R5"; end
      else if (is_conf_code) t = "R6";
      else if (op_size == 2'b00) t = "R8";
      else t = "R9";
      m_vld <= 1;
      m_we  <= ok;
      m_zf  <= ok;
      if (!ok) m_val <= 64'd0;
      else if (op_size == 2'b00) m_val <= {32'd0, ar_word & 32'h0000FF00};
      else m_val <= {32'd0, ar_word & 32'h00F0FF00};
      m_tag  <= t;
      m_ftag <= ok ? "R7" : "R10";
    end
  end

  task automatic chk(input bit c, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      chk(res_vld === m_vld, "R2", "res_vld", {63'd0, res_vld}, {63'd0, m_vld});
      chk(zf === m_zf, m_ftag, "zf", {63'd0, zf}, {63'd0, m_zf});
      chk(dest_we === m_we, m_ftag, "dest_we", {63'd0, dest_we}, {63'd0, m_we});
      chk(dest_val === m_val, m_tag, "dest_val", dest_val, m_val);
    end
  end

  task automatic drive(input bit v, input logic [15:0] off, input logic [15:0] lim,
                       input logic [3:0] ty, input logic [15:0] msk, input bit cc,
                       input logic [1:0] dpl, input logic [1:0] cpl, input logic [1:0] rpl,
                       input logic [31:0] ar, input logic [1:0] os);
    @(negedge clk);
    req_vld = v; sel_off = off; tbl_limit = lim; desc_type = ty; type_ok_mask = msk;
    is_conf_code = cc; desc_dpl = dpl; cur_pl = cpl; req_pl = rpl; ar_word = ar; op_size = os;
  endtask

  task automatic idle_rand();
    drive(0, 16'($urandom), 16'($urandom), 4'($urandom), 16'($urandom), 1'($urandom),
          2'($urandom), 2'($urandom), 2'($urandom), $urandom, 2'($urandom));
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    rst_n = 0;
    req_vld = 0; sel_off = 0; tbl_limit = 0; desc_type = 0; type_ok_mask = 0;
    is_conf_code = 0; desc_dpl = 0; cur_pl = 0; req_pl = 0; ar_word = 0; op_size = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(res_vld === 1'b0 && dest_we === 1'b0 && zf === 1'b0 && dest_val === 64'd0,
        "R1", "reset outputs", dest_val, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(res_vld === 1'b0 && zf === 1'b0 && dest_val === 64'd0,
        "R1", "after release", dest_val, 64'd0);
    model_on = 1;
    // R8 16-bit success
    drive(1, 16'h10, 16'h20, 4'h2, 16'hFFFF, 0, 2'd3, 2'd1, 2'd2, 32'hDEADBEEF, 2'b00);
    // R9 32-bit and both 64-bit codes
    drive(1, 16'h10, 16'h20, 4'h2, 16'hFFFF, 0, 2'd3, 2'd1, 2'd2, 32'hFFFFFFFF, 2'b01);
    drive(1, 16'h10, 16'h20, 4'h2, 16'hFFFF, 0, 2'd3, 2'd1, 2'd2, 32'hA5A5A5A5, 2'b10);
    drive(1, 16'h10, 16'h20, 4'h2, 16'hFFFF, 0, 2'd3, 2'd1, 2'd2, 32'h5A5A5A5A, 2'b11);
    // R3 limit equal passes, one beyond fails
    drive(1, 16'h40, 16'h40, 4'h1, 16'hFFFF, 0, 2'd0, 2'd0, 2'd0, 32'h12345678, 2'b01);
    drive(1, 16'h41, 16'h40, 4'h1, 16'hFFFF, 0, 2'd0, 2'd0, 2'd0, 32'h12345678, 2'b01);
    // R11 idle holds after a failure and after a success
    idle_rand(); idle_rand();
    drive(1, 16'h0, 16'h0, 4'h1, 16'hFFFF, 0, 2'd0, 2'd0, 2'd0, 32'hFFFFFFFF, 2'b01);
    idle_rand(); idle_rand();
    // R4 type mask bit clear
    drive(1, 16'h0, 16'h8, 4'h7, 16'hFF7F, 0, 2'd3, 2'd0, 2'd0, 32'hFFFFFFFF, 2'b01);
    // R5 cpl > dpl, rpl > dpl
    drive(1, 16'h0, 16'h8, 4'h7, 16'hFFFF, 0, 2'd1, 2'd2, 2'd0, 32'hFFFFFFFF, 2'b01);
    drive(1, 16'h0, 16'h8, 4'h7, 16'hFFFF, 0, 2'd1, 2'd0, 2'd3, 32'hFFFFFFFF, 2'b01);
    // R6 conforming ignores privilege
    drive(1, 16'h0, 16'h8, 4'hE, 16'hFFFF, 1, 2'd0, 2'd3, 2'd3, 32'hFFFFFFFF, 2'b00);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) idle_rand();
      else begin
        logic [15:0] lim;
        lim = 16'($urandom_range(2, 60000));
        drive(1, lim + 16'($urandom_range(0, 4)) - 16'd2, lim, 4'($urandom),
              16'($urandom) | 16'($urandom), 1'($urandom_range(0, 3) == 0),
              2'($urandom), 2'($urandom), 2'($urandom), $urandom, 2'($urandom));
      end
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    model_on = 0;
    finish_up();
  end
endmodule